// File: doc/BRIEF.md
# Nibble-Packed Return Address Stack

This block keeps a stack of 12-bit return addresses inside a small RAM of 256 four-bit cells. Every entry takes a slot of four neighbouring cells: the three lower cells of the slot hold the address and the fourth cell is never touched by the stack. Surrounding logic may keep its own 4-bit variables in that fourth cell. An 8-bit pointer names the slot of the top entry and moves in steps of four.

The RAM has a single write port, so the stack writes or reads one cell per clock. A push or a pop is accepted in one cycle and then takes three more cycles. A `busy` output stays high during those cycles. The pointer can be loaded directly and read at any time. A separate nibble port lets the rest of the design read any cell and write any cell while the stack is idle. That port is also how the untouched cells are used.

Top module: `ret_stack_nib`

## Requirements
- R1: While and after reset, `ptr_rdata` is FCh, `busy` is 0 and `pop_valid` is 0.
- R2: An accepted push adds 4 to the pointer (pre-increment). The new value shows on `ptr_rdata` in the cycle after acceptance.
- R3: A push whose new pointer is P stores address bits [3:0] at cell P, bits [7:4] at P+1 and bits [11:8] at P+2. All cell addresses wrap modulo 256.
- R4: Cell P+3 of a slot is never written by a push or a pop. Its value stays the same across both.
- R5: An accepted pop reads the entry at cells P..P+2, where P is the current pointer. In the fourth cycle after acceptance, `pop_valid` is high for one cycle, `pop_addr` holds the entry, and the pointer has dropped by 4 (post-decrement).
- R6: `busy` is high for exactly three cycles after a push or pop is accepted. Push, pop and load requests made while busy are ignored.
- R7: A request is accepted only while idle, in this priority: `ptr_load` first, then `push_req`, then `pop_req`. A load sets the pointer in the next cycle and does not raise `busy`.
- R8: The pointer wraps modulo 256: a push from FCh moves it to 00h, and a pop from 00h moves it to FCh.
- R9: `var_rdata` always shows the cell at `var_addr`. `var_we` writes `var_wdata` to that cell at the clock edge only when `busy` is 0; otherwise the write is dropped.
- R10: Entries come back in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Request to push `push_addr` |
| push_addr | input | 12 | Return address to store |
| pop_req | input | 1 | Request to pop the top entry |
| pop_addr | output | 12 | Entry returned by the last pop |
| pop_valid | output | 1 | One-cycle strobe: `pop_addr` is new |
| ptr_load | input | 1 | Request to overwrite the pointer |
| ptr_wdata | input | 8 | Value for the pointer load |
| ptr_rdata | output | 8 | Current stack pointer |
| busy | output | 1 | A push or pop is in progress |
| var_we | input | 1 | Nibble write strobe |
| var_addr | input | 8 | Nibble cell address |
| var_wdata | input | 4 | Nibble write data |
| var_rdata | output | 4 | Nibble read data at `var_addr` |

## Verification
The assertions assume the inputs are two-state after reset. They also assume that whoever drives the block reads `busy` before counting on a request being taken. They do not assume requests stay low while busy, because such requests must be dropped, and the bench deliberately raises them mid-operation. The bench changes every input half a period away from the rising edge. It drives the pointer only to slot-aligned values, so the two low pointer bits never change, which is the condition one of the properties relies on.

// File: rtl/rstk_pkg.sv
// Shared types for the nibble-packed return stack.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rstk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2
    } rstk_state_e;
endpackage

// File: rtl/rstk_ptr.sv
// Stack pointer register.
// Holds the slot address of the top entry. It moves by STEP on an
// increment or decrement, or takes a new value on a load.
// Assumes: at most one of inc/dec/load is high in any cycle.
module rstk_ptr #(
    parameter int          ADDR_W    = 8,
    parameter int          STEP      = 4,
    parameter logic [7:0]  RESET_PTR = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Pointer update with wrap modulo 2**ADDR_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= ADDR_W'(RESET_PTR);
        else if (load)
            ptr <= load_val;
        else if (inc)
            ptr <= ptr + STEP_V;
        else if (dec)
            ptr <= ptr - STEP_V;
    end
endmodule

// File: rtl/rstk_nibram.sv
// Nibble RAM model: one write port and two asynchronous read ports.
// Assumes: the cells have no reset; a cell holds its value until written.
module rstk_nibram #(
    parameter int ADDR_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [NIB_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [NIB_W-1:0]  rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [NIB_W-1:0]  rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [NIB_W-1:0] cells [DEPTH];

    // Single write port.
    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    // Combinational read ports.
    always_comb begin
        rdata_a = cells[raddr_a];
        rdata_b = cells[raddr_b];
    end
endmodule

// File: rtl/rstk_seq.sv
// Push/pop sequencer.
// Accepts one request while idle, then moves one nibble per cycle.
// Only slot offsets 0..ENTRY_NIBS-1 are ever addressed, so the
// remaining cells of a slot are never touched.
// Assumes: the pointer from rstk_ptr already reflects ptr_inc on the
// cycle after acceptance (pre-increment).
module rstk_seq
    import rstk_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NIB_W      = 4,
    parameter int ENTRY_NIBS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_req,
    input  logic                        pop_req,
    input  logic                        ptr_load,
    input  logic [ENTRY_NIBS*NIB_W-1:0] push_data,
    input  logic [ADDR_W-1:0]           ptr,
    input  logic [NIB_W-1:0]            ram_rdata,
    output logic                        ptr_inc,
    output logic                        ptr_dec,
    output logic                        ptr_set,
    output logic                        ram_we,
    output logic [ADDR_W-1:0]           ram_addr,
    output logic [NIB_W-1:0]            ram_wdata,
    output logic                        busy,
    output logic [ENTRY_NIBS*NIB_W-1:0] pop_data,
    output logic                        pop_valid
);
    localparam int            PH_W = (ENTRY_NIBS > 1) ? $clog2(ENTRY_NIBS) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(ENTRY_NIBS - 1);

    rstk_state_e                         state;
    logic [PH_W-1:0]                     phase;
    logic [ENTRY_NIBS-1:0][NIB_W-1:0]    hold;
    logic [ENTRY_NIBS-1:0][NIB_W-1:0]    acc;
    logic [ENTRY_NIBS-1:0][NIB_W-1:0]    assembled;
    logic                                idle;
    logic                                push_go;
    logic                                pop_go;

    // Acceptance decode with load > push > pop priority.
    always_comb begin
        idle    = (state == ST_IDLE);
        ptr_set = idle && ptr_load;
        push_go = idle && !ptr_load && push_req;
        pop_go  = idle && !ptr_load && !push_req && pop_req;
    end

    // RAM and pointer controls for the current phase.
    always_comb begin
        busy      = !idle;
        ptr_inc   = push_go;
        ptr_dec   = (state == ST_POP) && (phase == LAST);
        ram_we    = (state == ST_PUSH);
        ram_addr  = ptr + ADDR_W'(phase);
        ram_wdata = hold[phase];
    end

    // Complete entry: collected nibbles plus the one read this cycle.
    always_comb begin
        assembled       = acc;
        assembled[LAST] = ram_rdata;
    end

    // State machine, data holding and pop result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= '0;
            hold      <= '0;
            acc       <= '0;
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    phase <= '0;
                    if (push_go) begin
                        hold  <= push_data;
                        state <= ST_PUSH;
                    end else if (pop_go) begin
                        state <= ST_POP;
                    end
                end
                ST_PUSH: begin
                    if (phase == LAST)
                        state <= ST_IDLE;
                    else
                        phase <= phase + 1'b1;
                end
                ST_POP: begin
                    acc[phase] <= ram_rdata;
                    if (phase == LAST) begin
                        pop_data  <= assembled;
                        pop_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ret_stack_nib.sv
// Nibble-packed return address stack, top level.
// Joins the pointer, the sequencer and the nibble RAM. It also routes
// the external nibble port, whose writes reach the RAM only while the
// sequencer is idle.
// Assumes: synchronous active-low reset; RAM contents are undefined
// until written.
module ret_stack_nib #(
    parameter int         ADDR_W     = 8,
    parameter int         NIB_W      = 4,
    parameter int         ENTRY_NIBS = 3,
    parameter int         SLOT_NIBS  = 4,
    parameter logic [7:0] RESET_PTR  = 8'hFC,
    localparam int        ENTRY_W    = ENTRY_NIBS * NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_req,
    input  logic [ENTRY_W-1:0] push_addr,
    input  logic               pop_req,
    output logic [ENTRY_W-1:0] pop_addr,
    output logic               pop_valid,
    input  logic               ptr_load,
    input  logic [ADDR_W-1:0]  ptr_wdata,
    output logic [ADDR_W-1:0]  ptr_rdata,
    output logic               busy,
    input  logic               var_we,
    input  logic [ADDR_W-1:0]  var_addr,
    input  logic [NIB_W-1:0]   var_wdata,
    output logic [NIB_W-1:0]   var_rdata
);
    logic              ptr_inc, ptr_dec, ptr_set;
    logic              seq_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [NIB_W-1:0]  seq_wdata, seq_rdata;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [NIB_W-1:0]  ram_wdata;

    rstk_ptr #(
        .ADDR_W    (ADDR_W),
        .STEP      (SLOT_NIBS),
        .RESET_PTR (RESET_PTR)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (ptr_inc),
        .dec      (ptr_dec),
        .load     (ptr_set),
        .load_val (ptr_wdata),
        .ptr      (ptr_rdata)
    );

    rstk_seq #(
        .ADDR_W     (ADDR_W),
        .NIB_W      (NIB_W),
        .ENTRY_NIBS (ENTRY_NIBS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .ptr_load  (ptr_load),
        .push_data (push_addr),
        .ptr       (ptr_rdata),
        .ram_rdata (seq_rdata),
        .ptr_inc   (ptr_inc),
        .ptr_dec   (ptr_dec),
        .ptr_set   (ptr_set),
        .ram_we    (seq_we),
        .ram_addr  (seq_addr),
        .ram_wdata (seq_wdata),
        .busy      (busy),
        .pop_data  (pop_addr),
        .pop_valid (pop_valid)
    );

    // Write port arbitration: the sequencer owns the port while busy.
    always_comb begin
        if (seq_we) begin
            ram_we    = 1'b1;
            ram_waddr = seq_addr;
            ram_wdata = seq_wdata;
        end else begin
            ram_we    = var_we && !busy;
            ram_waddr = var_addr;
            ram_wdata = var_wdata;
        end
    end

    rstk_nibram #(
        .ADDR_W (ADDR_W),
        .NIB_W  (NIB_W)
    ) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (seq_addr),
        .rdata_a (seq_rdata),
        .raddr_b (var_addr),
        .rdata_b (var_rdata)
    );
endmodule

// File: rtl/ret_stack_nib_chk.sv
// Property checker for ret_stack_nib, bound to every instance.
// Assumes: the pointer is only ever loaded with slot-aligned values.
module ret_stack_nib_chk #(
    parameter int ADDR_W    = 8,
    parameter int ENTRY_W   = 12,
    parameter int NIB_W     = 4,
    parameter int SLOT_NIBS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               push_req,
    input logic [ENTRY_W-1:0] push_addr,
    input logic               pop_req,
    input logic [ENTRY_W-1:0] pop_addr,
    input logic               pop_valid,
    input logic               ptr_load,
    input logic [ADDR_W-1:0]  ptr_wdata,
    input logic [ADDR_W-1:0]  ptr_rdata,
    input logic               busy,
    input logic               var_we,
    input logic [ADDR_W-1:0]  var_addr,
    input logic [NIB_W-1:0]   var_wdata,
    input logic [NIB_W-1:0]   var_rdata
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(SLOT_NIBS);

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push_req && !ptr_load) |=> (busy && ptr_rdata == ADDR_W'($past(ptr_rdata) + STEP_V)));

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> (!busy && ptr_rdata == ADDR_W'($past(ptr_rdata) - STEP_V)));

    // R5
    pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> !pop_valid);

    // R6
    busy_hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(ptr_rdata));

    // R7
    load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ptr_load) |=> (!busy && ptr_rdata == $past(ptr_wdata)));

    // R8
    slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_load |=> (ptr_rdata[1:0] == $past(ptr_rdata[1:0])));
endmodule

bind ret_stack_nib ret_stack_nib_chk #(
    .ADDR_W    (ADDR_W),
    .ENTRY_W   (ENTRY_W),
    .NIB_W     (NIB_W),
    .SLOT_NIBS (SLOT_NIBS)
) u_chk (.*);

// File: tb/ret_stack_nib_bench.sv
module ret_stack_nib_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OP_PUSH = 0, OP_POP = 1, OP_LOAD = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] data;
        logic [7:0]  exp_ptr;
        logic [11:0] exp_pop;
    } vec_t;

    // R2 R5 R8 R10: sequence walked from the reset pointer FCh.
    localparam vec_t VECS [12] = '{
        '{2'd2, 12'h010, 8'h10, 12'h000},
        '{2'd0, 12'hA5C, 8'h14, 12'h000},
        '{2'd0, 12'h3B7, 8'h18, 12'h000},
        '{2'd0, 12'hFFF, 8'h1C, 12'h000},
        '{2'd1, 12'h000, 8'h18, 12'hFFF},
        '{2'd0, 12'h012, 8'h1C, 12'h000},
        '{2'd1, 12'h000, 8'h18, 12'h012},
        '{2'd1, 12'h000, 8'h14, 12'h3B7},
        '{2'd1, 12'h000, 8'h10, 12'hA5C},
        '{2'd2, 12'h0FC, 8'hFC, 12'h000},
        '{2'd0, 12'h9E1, 8'h00, 12'h000},
        '{2'd1, 12'h000, 8'hFC, 12'h9E1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0;
    logic [11:0] push_addr = '0;
    logic        pop_req = 1'b0;
    logic [11:0] pop_addr;
    logic        pop_valid;
    logic        ptr_load = 1'b0;
    logic [7:0]  ptr_wdata = '0;
    logic [7:0]  ptr_rdata;
    logic        busy;
    logic        var_we = 1'b0;
    logic [7:0]  var_addr = '0;
    logic [3:0]  var_wdata = '0;
    logic [3:0]  var_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ret_stack_nib u_ret_stack_nib (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    // Each op task starts and ends just after a falling edge.
    task automatic do_load(input logic [7:0] v);
        ptr_load = 1'b1; ptr_wdata = v;
        @(posedge clk); @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic do_push(input logic [11:0] d);
        push_req = 1'b1; push_addr = d;
        @(posedge clk); @(negedge clk);
        push_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_pop();
        pop_req = 1'b1;
        @(posedge clk); @(negedge clk);
        pop_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic var_write(input logic [7:0] a, input logic [3:0] d);
        var_we = 1'b1; var_addr = a; var_wdata = d;
        @(posedge clk); @(negedge clk);
        var_we = 1'b0;
    endtask

    task automatic var_peek(input string req, input logic [7:0] a, input logic [3:0] exp);
        var_addr = a;
        #1;
        chk(req, var_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ptr", ptr_rdata, 8'hFC);
        chk("R1 busy", busy, 0);
        chk("R1 pop_valid", pop_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ptr after release", ptr_rdata, 8'hFC);

        // Table walk (R2 R5 R8 R10)
        foreach (VECS[i]) begin
            case (int'(VECS[i].op))
                OP_LOAD: do_load(VECS[i].exp_ptr);
                OP_PUSH: do_push(VECS[i].data);
                default: begin
                    do_pop();
                    chk("R5 pop_valid", pop_valid, 1);
                    chk("R10 pop_addr", pop_addr, VECS[i].exp_pop);
                end
            endcase
            chk("R2/R5/R8 ptr", ptr_rdata, VECS[i].exp_ptr);
        end

        // R8: pop from 00h wraps to FCh (entry 9E1 still sits at 00h)
        do_load(8'h00);
        do_pop();
        chk("R8 pop data", pop_addr, 12'h9E1);
        chk("R8 ptr wrap", ptr_rdata, 8'hFC);

        // R9 R4: preset spare cell of slot 44h, then push 7C3 at ptr 40h
        do_load(8'h40);
        var_write(8'h47, 4'h6);
        var_peek("R9 var write", 8'h47, 4'h6);
        var_write(8'h43, 4'hD);
        push_req = 1'b1; push_addr = 12'h7C3;
        @(posedge clk); @(negedge clk);
        push_req = 1'b0;
        // R6: busy three cycles; requests and var writes ignored
        chk("R6 busy c1", busy, 1);
        chk("R2 ptr pre-inc", ptr_rdata, 8'h44);
        pop_req = 1'b1; ptr_load = 1'b1; ptr_wdata = 8'h80;
        var_we = 1'b1; var_addr = 8'h90; var_wdata = 4'hF;
        @(negedge clk);
        chk("R6 busy c2", busy, 1);
        pop_req = 1'b0; ptr_load = 1'b0; var_we = 1'b0;
        @(negedge clk);
        chk("R6 busy c3", busy, 1);
        @(negedge clk);
        chk("R6 busy done", busy, 0);
        chk("R6 ptr unchanged", ptr_rdata, 8'h44);
        chk("R6 pop ignored", pop_valid, 0);
        // R3: nibble layout
        var_peek("R3 nib0", 8'h44, 4'h3);
        var_peek("R3 nib1", 8'h45, 4'hC);
        var_peek("R3 nib2", 8'h46, 4'h7);
        var_peek("R4 spare after push", 8'h47, 4'h6);
        var_peek("R4 slot below spare", 8'h43, 4'hD);
        var_write(8'h90, 4'h2);
        var_peek("R9 write data", 8'h90, 4'h2);
        do_pop();
        chk("R5 pop 7C3", pop_addr, 12'h7C3);
        chk("R5 ptr", ptr_rdata, 8'h40);
        var_peek("R4 spare after pop", 8'h47, 4'h6);

        // R9: write while busy is dropped
        var_write(8'h91, 4'h5);
        push_req = 1'b1; push_addr = 12'h111;
        @(posedge clk); @(negedge clk);
        push_req = 1'b0;
        var_we = 1'b1; var_addr = 8'h91; var_wdata = 4'hA;
        @(negedge clk);
        var_we = 1'b0;
        repeat (2) @(negedge clk);
        var_peek("R9 busy write dropped", 8'h91, 4'h5);

        // R7: load beats push
        ptr_load = 1'b1; ptr_wdata = 8'h20; push_req = 1'b1; push_addr = 12'h222;
        @(posedge clk); @(negedge clk);
        ptr_load = 1'b0; push_req = 1'b0;
        chk("R7 load wins ptr", ptr_rdata, 8'h20);
        chk("R7 load no busy", busy, 0);
        // R7: push beats pop
        push_req = 1'b1; pop_req = 1'b1; push_addr = 12'hBEE;
        @(posedge clk); @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        chk("R7 push wins ptr", ptr_rdata, 8'h24);
        repeat (3) @(negedge clk);
        do_pop();
        chk("R7 pushed entry", pop_addr, 12'hBEE);

        // R1: reset mid-operation
        push_req = 1'b1; push_addr = 12'h333;
        @(posedge clk); @(negedge clk);
        push_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset ptr", ptr_rdata, 8'hFC);
        chk("R1 reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule